// File: doc/BRIEF.md
# Image Sensor Row/Column Address Sequencer

This block models and controls the selection register that walks an image sensor's rows or columns during a frame. A slow shift clock and an active-low start pulse come from the sensor timing generator. The block tracks which line is selected after each falling edge of that shift clock. It reports the selected position, and it flags dark, dummy and end-of-scan positions. It also gives a separate index that is non-zero only for real image positions.

One parameter sets the axis. The row axis is used twice, once for the readout pointer and once for the reset pointer. The column axis adds a leading dark position. A mode input, sampled at each accepted start, picks full resolution (stride 1) or a 4:1 viewfinder subsample (stride 4). A start pulse is legal only while the shift clock is high. An illegal one is reported with a one-cycle error pulse and otherwise ignored.

All inputs are synchronous to the system clock `clk`. Shift-clock and start edges are found by comparing each input with its value one system clock earlier.

Top module: `scan_addr_seq`

## Requirements
- R1: A high-to-low transition of `start_n_i` while `shift_clk_i` is high restarts the scan: on the next clock every output is 0 and no position is selected. A transition while `shift_clk_i` is low raises `start_err_o` for exactly one `clk` cycle and changes no other output.
- R2: The selection changes only on a falling edge of `shift_clk_i`. Rising edges and steady levels leave all position outputs unchanged.
- R3: Row axis, full mode: the k-th falling edge after start selects row k (`sel_o` = k) for k = 1..1030, and edge 1031 raises `eos_o`.
- R4: Row axis, viewfinder mode: the selected rows are 1, 5, 9, …, row 1029 is selected on edge 258, and `eos_o` is raised on edge 259.
- R5: Column axis, both modes: edge 1 raises `dark_o` with `sel_o` = 0, and edge 2 selects column 1.
- R6: Column axis, full mode: the stride is 1, column 1286 is selected on edge 1287, and `eos_o` is raised on edge 1288.
- R7: Column axis, viewfinder mode: the selected columns are 1, 5, 9, …, column 1285 is selected on edge 323, and `eos_o` is raised on edge 324.
- R8: `dummy_o` is high in full mode for positions 1–3 and for the last three positions (rows 1028–1030, columns 1284–1286), and in viewfinder mode for position 1 only.
- R9: Once `eos_o` is high it stays high through any number of further falling edges until the next legal start.
- R10: `vf_mode_i` is sampled only at a legal start (1 = viewfinder, 0 = full). A change during a scan has no effect until the next legal start.
- R11: `img_vld_o` is high exactly when a selected position is not a dummy, and `img_idx_o` equals `sel_o` then and 0 otherwise. At most one of `dark_o`, `dummy_o`, `eos_o` and `img_vld_o` is high.
- R12: After reset, and on falling edges before the first legal start, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk_i | input | 1 | Sensor shift clock; the selection advances on its falling edge |
| start_n_i | input | 1 | Active-low start pulse; legal only while shift_clk_i is high |
| vf_mode_i | input | 1 | 1 = 4:1 viewfinder subsample, 0 = full resolution; sampled at start |
| sel_o | output | 11 | Selected row/column number, 0 when none |
| dark_o | output | 1 | Leading dark position selected (column axis) |
| dummy_o | output | 1 | Selected position is a border dummy |
| eos_o | output | 1 | End of scan reached |
| img_vld_o | output | 1 | Selected position is an image position |
| img_idx_o | output | 11 | Image position number, 0 unless img_vld_o |
| start_err_o | output | 1 | One-cycle pulse for a start seen while shift_clk_i is low |

## Verification
A wrong position counter or stride shows up on `sel_o` one system clock after the falling edge that caused it. It keeps showing there for the rest of the scan, because every later value builds on it. A wrong state, such as a missing dark step or an early or late end, moves every later position by one edge. It also moves the time `eos_o` is raised. The bench therefore compares every edge of whole scans in both modes on both axes, and it adds exact checks at the first, border and final positions. A mode latched at the wrong time is caught within a few edges of a mid-scan mode change, because the stride differs.

// File: rtl/scan_seq_pkg.sv
// Package: shared types for the scan address sequencer.
// Assumes: positions are numbered from 1; 0 means "nothing selected".
package scan_seq_pkg;

    // Sequencer state: idle until a legal start, then armed, optional dark, run, end.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_DARK  = 3'd2,
        ST_RUN   = 3'd3,
        ST_EOS   = 3'd4
    } seq_st_t;

    // Largest position reachable from 1 with the given stride without passing n.
    function automatic int last_on_grid(input int n, input int stride);
        return 1 + stride * ((n - 1) / stride);
    endfunction

endpackage

// File: rtl/sq_front.sv
// Module: sq_front
// Finds falling edges of the shift clock and start pulses, and judges start legality.
// Assumes: both inputs are synchronous to clk; edges are found one clk after they
// appear, against the value held from the previous clk.
module sq_front (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk_i,
    input  logic start_n_i,
    output logic fall_o,
    output logic start_ok_o,
    output logic start_err_o
);

    logic shift_q;
    logic start_n_q;
    logic start_edge;

    // Hold the previous input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= 1'b0;
            start_n_q <= 1'b0;
        end else begin
            shift_q   <= shift_clk_i;
            start_n_q <= start_n_i;
        end
    end

    // Decode edges; a start is accepted only while the shift clock is high.
    always_comb begin
        fall_o     = shift_q & ~shift_clk_i;
        start_edge = start_n_q & ~start_n_i;
        start_ok_o = start_edge & shift_clk_i;
    end

    // Pulse the error flag for one clk when a start arrives with the shift clock low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_err_o <= 1'b0;
        end else begin
            start_err_o <= start_edge & ~shift_clk_i;
        end
    end

    // R1: the error pulse never lasts longer than one clk.
    a_r1_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |=> !start_err_o);

endmodule

// File: rtl/sq_step.sv
// Module: sq_step
// Holds the sequencer state and the selected position; steps it on each shift-clock fall.
// Assumes: fall_i and start_ok_i never coincide (one needs the shift clock low, the
// other high). The column axis inserts one dark step before position 1.
module sq_step
    import scan_seq_pkg::*;
#(
    parameter bit IS_COL = 1'b0,
    parameter int N_POS  = 1030,
    parameter int SUB    = 4,
    parameter int POS_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             start_ok_i,
    input  logic             vf_req_i,
    output seq_st_t          st_o,
    output logic [POS_W-1:0] pos_o,
    output logic             vf_o
);

    localparam int               LAST_VF_I   = last_on_grid(N_POS, SUB);
    localparam logic [POS_W-1:0] LAST_FULL   = POS_W'(N_POS);
    localparam logic [POS_W-1:0] LAST_VF     = POS_W'(LAST_VF_I);
    localparam logic [POS_W-1:0] STRIDE_FULL = POS_W'(1);
    localparam logic [POS_W-1:0] STRIDE_VF   = POS_W'(SUB);
    localparam logic [POS_W-1:0] FIRST_POS   = POS_W'(1);

    seq_st_t          st_q, st_n;
    logic [POS_W-1:0] pos_q, pos_n;
    logic             vf_q;
    logic [POS_W-1:0] last_w, step_w;
    seq_st_t          lead_st;
    logic [POS_W-1:0] lead_pos;

    // Axis variant: the column axis starts with a dark step, the row axis with row 1.
    generate
        if (IS_COL) begin : g_col
            assign lead_st  = ST_DARK;
            assign lead_pos = '0;
        end else begin : g_row
            assign lead_st  = ST_RUN;
            assign lead_pos = FIRST_POS;
        end
    endgenerate

    // Pick the end position and stride for the mode latched at start.
    always_comb begin
        last_w = vf_q ? LAST_VF   : LAST_FULL;
        step_w = vf_q ? STRIDE_VF : STRIDE_FULL;
    end

    // Next state and position: restart on a legal start, else advance on a fall.
    always_comb begin
        st_n  = st_q;
        pos_n = pos_q;
        if (start_ok_i) begin
            st_n  = ST_ARMED;
            pos_n = '0;
        end else if (fall_i) begin
            case (st_q)
                ST_ARMED: begin
                    st_n  = lead_st;
                    pos_n = lead_pos;
                end
                ST_DARK: begin
                    st_n  = ST_RUN;
                    pos_n = FIRST_POS;
                end
                ST_RUN: begin
                    if (pos_q == last_w) begin
                        st_n  = ST_EOS;
                        pos_n = '0;
                    end else begin
                        pos_n = pos_q + step_w;
                    end
                end
                default: begin
                    st_n  = st_q;
                    pos_n = pos_q;
                end
            endcase
        end
    end

    // State, position and latched mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
            vf_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            pos_q <= pos_n;
            if (start_ok_i) begin
                vf_q <= vf_req_i;
            end
        end
    end

    assign st_o  = st_q;
    assign pos_o = pos_q;
    assign vf_o  = vf_q;

    // R2: without a fall or a start, nothing moves.
    a_r2_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_i && !start_ok_i) |=> ($stable(pos_q) && $stable(st_q)));

    // R3: inside a run, each fall moves by the latched stride until the last position.
    a_r3_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && fall_i && pos_q != last_w) |=> (pos_q == $past(pos_q) + $past(step_w)));

    // R9: end of scan is kept until a legal start.
    a_r9_eos_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EOS && !start_ok_i) |=> (st_q == ST_EOS));

    // R10: the latched mode only changes at a legal start.
    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !start_ok_i |=> $stable(vf_q));

endmodule

// File: rtl/sq_flags.sv
// Module: sq_flags
// Turns state and position into the selection, dark, dummy, end and image outputs.
// Assumes: position 0 is used whenever no row or column is selected.
module sq_flags
    import scan_seq_pkg::*;
#(
    parameter int N_POS  = 1030,
    parameter int BORDER = 3,
    parameter int POS_W  = 11
) (
    input  seq_st_t          st_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             vf_i,
    output logic [POS_W-1:0] sel_o,
    output logic             dark_o,
    output logic             dummy_o,
    output logic             eos_o,
    output logic             img_vld_o,
    output logic [POS_W-1:0] img_idx_o
);

    localparam logic [POS_W-1:0] LOW_EDGE  = POS_W'(BORDER);
    localparam logic [POS_W-1:0] HIGH_EDGE = POS_W'(N_POS - BORDER);
    localparam logic [POS_W-1:0] FIRST_POS = POS_W'(1);

    logic running;
    logic border_hit;

    // Border test: full mode flags both edges, viewfinder only the first position.
    always_comb begin
        running    = (st_i == ST_RUN);
        border_hit = vf_i ? (pos_i == FIRST_POS)
                          : ((pos_i <= LOW_EDGE) || (pos_i > HIGH_EDGE));
    end

    // Output decode from state and position.
    always_comb begin
        sel_o     = running ? pos_i : '0;
        dark_o    = (st_i == ST_DARK);
        eos_o     = (st_i == ST_EOS);
        dummy_o   = running && border_hit;
        img_vld_o = running && !border_hit;
        img_idx_o = img_vld_o ? pos_i : '0;
    end

endmodule

// File: rtl/scan_addr_seq.sv
// Module: scan_addr_seq (top)
// Row or column address sequencer for an image sensor's selection register.
// Assumes: all inputs are synchronous to clk and each shift-clock phase lasts at
// least one clk. IS_COL picks the column axis (leading dark step, N_COL positions);
// otherwise the row axis (N_ROW positions).
module scan_addr_seq
    import scan_seq_pkg::*;
#(
    parameter bit IS_COL = 1'b0,
    parameter int N_ROW  = 1030,
    parameter int N_COL  = 1286,
    parameter int SUB    = 4,
    parameter int BORDER = 3,
    parameter int POS_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_clk_i,
    input  logic             start_n_i,
    input  logic             vf_mode_i,
    output logic [POS_W-1:0] sel_o,
    output logic             dark_o,
    output logic             dummy_o,
    output logic             eos_o,
    output logic             img_vld_o,
    output logic [POS_W-1:0] img_idx_o,
    output logic             start_err_o
);

    localparam int N_POS = IS_COL ? N_COL : N_ROW;

    logic             fall_w;
    logic             start_ok_w;
    seq_st_t          st_w;
    logic [POS_W-1:0] pos_w;
    logic             vf_w;

    sq_front u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_clk_i (shift_clk_i),
        .start_n_i   (start_n_i),
        .fall_o      (fall_w),
        .start_ok_o  (start_ok_w),
        .start_err_o (start_err_o)
    );

    sq_step #(
        .IS_COL (IS_COL),
        .N_POS  (N_POS),
        .SUB    (SUB),
        .POS_W  (POS_W)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall_w),
        .start_ok_i (start_ok_w),
        .vf_req_i   (vf_mode_i),
        .st_o       (st_w),
        .pos_o      (pos_w),
        .vf_o       (vf_w)
    );

    sq_flags #(
        .N_POS  (N_POS),
        .BORDER (BORDER),
        .POS_W  (POS_W)
    ) u_flags (
        .st_i      (st_w),
        .pos_i     (pos_w),
        .vf_i      (vf_w),
        .sel_o     (sel_o),
        .dark_o    (dark_o),
        .dummy_o   (dummy_o),
        .eos_o     (eos_o),
        .img_vld_o (img_vld_o),
        .img_idx_o (img_idx_o)
    );

    // R1: an illegal start, with no fall in the same clk, leaves the outputs alone.
    a_r1_bad_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_err_o && !$past(fall_w)) |-> ($stable(sel_o) && $stable(eos_o) && $stable(dark_o)));

    // R11: the position classes never overlap.
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dark_o, dummy_o, eos_o, img_vld_o}));

    // R8: a dummy or image position always carries a selected number.
    a_r8_dummy_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (dummy_o || img_vld_o) |-> (sel_o != '0));

endmodule

// File: tb/sim_scan_addr_seq.sv
// Bench for scan_addr_seq: a row-axis instance (u0) and a column-axis instance (u1)
// share one stimulus stream; expected outputs come from a bench model of the requirements.
module sim_scan_addr_seq;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, sclk, start_n, vf;
    logic [10:0] y_sel, y_idx, x_sel, x_idx;
    logic y_dark, y_dum, y_eos, y_vld, y_err;
    logic x_dark, x_dum, x_eos, x_vld, x_err;

    int  n_vec = 0;
    int  n_bad = 0;
    int  k     = 0;
    bit  vf_l  = 1'b0;
    bit  armed = 1'b0;
    bit  done  = 1'b0;

    scan_addr_seq #(.IS_COL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_clk_i(sclk), .start_n_i(start_n), .vf_mode_i(vf),
        .sel_o(y_sel), .dark_o(y_dark), .dummy_o(y_dum), .eos_o(y_eos),
        .img_vld_o(y_vld), .img_idx_o(y_idx), .start_err_o(y_err));

    scan_addr_seq #(.IS_COL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .shift_clk_i(sclk), .start_n_i(start_n), .vf_mode_i(vf),
        .sel_o(x_sel), .dark_o(x_dark), .dummy_o(x_dum), .eos_o(x_eos),
        .img_vld_o(x_vld), .img_idx_o(x_idx), .start_err_o(x_err));

    // Expected {sel, dark, dummy, eos, vld} after kk falls since the last legal start.
    function automatic logic [14:0] model(bit col, bit vfm, int kk, bit arm);
        int n, lastj, j, s;
        logic [10:0] sel;
        logic dk, du, eo, vl;
        n = col ? 1286 : 1030;
        lastj = vfm ? ((n - 1) / 4 + 1) : n;
        j = kk - (col ? 1 : 0);
        sel = '0; dk = 0; du = 0; eo = 0; vl = 0;
        if (arm && kk > 0) begin
            if (col && kk == 1) dk = 1'b1;
            else if (j <= lastj) begin
                s   = vfm ? (1 + 4 * (j - 1)) : j;
                sel = 11'(s);
                du  = vfm ? (s == 1) : (s <= 3 || s > n - 3);
                vl  = !du;
            end else eo = 1'b1;
        end
        return {sel, dk, du, eo, vl};
    endfunction

    // Compare both instances against the model.
    task automatic chk(string req, bit exp_err);
        logic [14:0] ey, ex, gy, gx;
        logic [10:0] eiy, eix;
        ey = model(1'b0, vf_l, k, armed);
        ex = model(1'b1, vf_l, k, armed);
        eiy = ey[0] ? ey[14:4] : 11'd0;
        eix = ex[0] ? ex[14:4] : 11'd0;
        gy = {y_sel, y_dark, y_dum, y_eos, y_vld};
        gx = {x_sel, x_dark, x_dum, x_eos, x_vld};
        n_vec += 2;
        if (gy !== ey || y_idx !== eiy || y_err !== exp_err) begin
            n_bad++;
            $display("FAIL %s row k=%0d: got %h idx=%0d err=%b, exp %h idx=%0d err=%b",
                     req, k, gy, y_idx, y_err, ey, eiy, exp_err);
        end
        if (gx !== ex || x_idx !== eix || x_err !== exp_err) begin
            n_bad++;
            $display("FAIL %s col k=%0d: got %h idx=%0d err=%b, exp %h idx=%0d err=%b",
                     req, k, gx, x_idx, x_err, ex, eix, exp_err);
        end
    endtask

    // Directed scalar check written straight from a requirement's numbers.
    task automatic dchk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s k=%0d: got %0d exp %0d", req, k, act, exp);
        end
    endtask

    // Exact endpoint and border checks for directed scans.
    task automatic endpoints();
        if (!vf_l) begin
            if (k == 3)    dchk("R8",  int'(y_dum), 1);
            if (k == 4)    dchk("R8",  int'(y_vld), 1);
            if (k == 1028) dchk("R8",  int'(y_dum), 1);
            if (k == 1030) dchk("R3",  int'(y_sel), 1030);
            if (k == 1031) dchk("R3",  int'(y_eos), 1);
            if (k == 1287) dchk("R6",  int'(x_sel), 1286);
            if (k == 1288) dchk("R6",  int'(x_eos), 1);
        end else begin
            if (k == 1)    dchk("R8",  int'(y_dum), 1);
            if (k == 2)    dchk("R4",  int'(y_sel), 5);
            if (k == 258)  dchk("R4",  int'(y_sel), 1029);
            if (k == 259)  dchk("R4",  int'(y_eos), 1);
            if (k == 323)  dchk("R7",  int'(x_sel), 1285);
            if (k == 324)  dchk("R7",  int'(x_eos), 1);
        end
        if (k == 1) dchk("R5", int'(x_dark), 1);
        if (k == 2) dchk("R5", int'(x_sel), 1);
        if (k == 1300) dchk("R9", int'(x_eos), 1);
    endtask

    // One shift-clock period: low phase (fall), optional illegal start, high phase.
    task automatic pulse(string req, int lo, int hi, bit bad_start, bit ends);
        sclk = 1'b0;
        if (armed) k++;
        repeat (lo) @(negedge clk);
        chk(req, 1'b0);
        if (ends) endpoints();
        if (bad_start) begin
            start_n = 1'b0;
            @(negedge clk);
            chk("R1", 1'b1);
            start_n = 1'b1;
            @(negedge clk);
            chk("R1", 1'b0);
        end
        sclk = 1'b1;
        repeat (hi) @(negedge clk);
        chk("R2", 1'b0);
    endtask

    // Legal start while the shift clock is high.
    task automatic start(bit mode);
        vf = mode;
        start_n = 1'b0;
        @(negedge clk);
        start_n = 1'b1;
        armed = 1'b1; k = 0; vf_l = mode;
        chk("R1", 1'b0);
        @(negedge clk);
        chk("R1", 1'b0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED);
        rst_n = 1'b0; sclk = 1'b1; start_n = 1'b1; vf = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", 1'b0);
        pulse("R12", 1, 1, 1'b0, 1'b0);
        pulse("R12", 2, 1, 1'b0, 1'b0);

        // Full-resolution directed scan past both ends.
        start(1'b0);
        for (int i = 0; i < 1300; i++) pulse("R3 R6 R8 R11", 1, 1, 1'b0, 1'b1);

        // Viewfinder scan with an illegal start and a mid-scan mode change.
        start(1'b1);
        for (int i = 0; i < 330; i++) begin
            if (i == 120) vf = 1'b0;
            pulse((i > 120) ? "R10" : "R4 R7 R8", 1, 1, (i == 50), 1'b1);
        end

        // Random scans: durations, mode flips, illegal starts, early restarts.
        for (int s = 0; s < 6; s++) begin
            int len;
            start(1'($urandom_range(0, 1)));
            len = $urandom_range(20, 420);
            for (int i = 0; i < len; i++) begin
                if ($urandom_range(0, 40) == 0) vf = ~vf;
                pulse("R11", $urandom_range(1, 3), $urandom_range(1, 3),
                      ($urandom_range(0, 60) == 0), 1'b0);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule